// File: doc/BRIEF.md
# Word-Interleaved Cache Slice

This block is one cluster's share of a first-level data cache that is split across four clusters. Consecutive 4-byte words of a 32-byte block rotate across the clusters, so the slice in cluster k holds only two words of every cached block: word k and word k+4. It also keeps its own copy of the block's tag. Overall the cache is 8 KB and two-way set-associative. Each slice stores 2 KB, laid out as 128 sets of two ways. Each way holds one tag, a valid flag, a dirty flag and one 64-bit subblock. Each set has one replacement bit.

Loads and stores reach the slice over a single request port. They can come from the slice's own cluster or from any other cluster, and each one carries the identifier of the requester. The slice accepts only requests for words it owns. It looks the request up, and on a miss it refills its own subblock from a next level that always hits. If the victim subblock is dirty, the slice writes it back first. Every access falls into one of four classes: local hit, remote hit, local miss or remote miss. The slice returns a one-cycle response on the requester's own response lane, timed by the class of the access. The cache contents are updated in the cycle the request is accepted. Only the response is delayed.

Top module: `wic_slice`

## Requirements
- R1: While reset is held and in the first cycle after it, no response lane is valid and no write-back is issued. After reset every way is invalid, so the first owned access to any address is a miss.
- R2: A request whose address bits [3:2] differ from the slice's cluster number is ignored. It produces no response and no write-back, and it leaves the cache contents unchanged.
- R3: An accepted access is a hit when a valid way of set address[11:5] holds tag address[31:12]. It is local when the requester number equals the slice's cluster number. The response class code is {miss, remote}: 0 local hit, 1 remote hit, 2 local miss, 3 remote miss.
- R4: For a request presented in cycle c, the requester's response lane is valid for exactly one cycle, namely cycle c+L. L is 1 for a local hit, 5 for a remote hit, 10 for a local miss and 15 for a remote miss.
- R5: A load returns the most recent value stored to that word by any requester, or the next level's value if the word was never stored. Address bit 4 selects word k (0) or word k+4 (1) of the subblock.
- R6: A store is write-allocate. Its response data is the stored word, and it marks the way dirty.
- R7: The refill address l2_rd_addr is the request address with bits [4:0] cleared. l2_rd_data carries word k in bits [31:0] and word k+4 in bits [63:32]. Only this subblock and its tag are filled.
- R8: In the cycle of a miss whose victim way is valid and dirty, l2_wr_en is high. l2_wr_addr then holds the victim's block address and l2_wr_data its two words, in the layout of R7. A clean or invalid victim causes no write-back.
- R9: On a miss the victim is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way that was not used by the most recent accepted access to that set.
- R10: A request from a requester whose previous response has not yet completed is dropped without response or state change. A requester's lane is free again in the cycle after its response.
- R11: Responses to different requesters may be valid in the same cycle, each on its own lane with its own data and class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 store, 0 load |
| req_src | input | 2 | Requesting cluster number |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 4 | Per-requester response pulse |
| rsp_data | output | 128 | Per-requester response word, lane n at bits [32n+31:32n] |
| rsp_kind | output | 8 | Per-requester class code, lane n at bits [2n+1:2n] |
| l2_rd_addr | output | 32 | Block address for the refill read |
| l2_rd_data | input | 64 | Refill subblock from the next level |
| l2_wr_en | output | 1 | Dirty-victim write-back this cycle |
| l2_wr_addr | output | 32 | Victim block address |
| l2_wr_data | output | 64 | Victim subblock |

## Verification
The hardest situation to reach from the ports is a write-back of a dirty victim that is later re-read through the next level. It needs two stores with different tags in one set, a third tag that evicts the least recently used of them, and then a return to the evicted tag. The random phase draws tags from a pool of three and sets from a pool of two, so conflicts and evictions happen all the time. Directed sequences force one such eviction and also make two responses of different classes fall in the same cycle.

// File: rtl/wic_pkg.sv
package wic_pkg;
    localparam int NUM_WAYS = 2;
    localparam int WORD_W   = 32;

    typedef enum logic [1:0] {
        KIND_LHIT  = 2'd0,
        KIND_RHIT  = 2'd1,
        KIND_LMISS = 2'd2,
        KIND_RMISS = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/wic_tag_store.sv
module wic_tag_store #(
    parameter int SETS  = 128,
    parameter int TAG_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  lk_set,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic                     hit_o,
    output logic                     hit_way_o,
    output logic                     vict_way_o,
    output logic                     vict_valid_o,
    output logic                     vict_dirty_o,
    output logic [TAG_W-1:0]         vict_tag_o,
    input  logic                     upd_en_i,
    input  logic                     upd_way_i,
    input  logic                     upd_refill_i,
    input  logic                     upd_write_i
);
    import wic_pkg::*;

    typedef struct packed {
        logic [SETS-1:0][NUM_WAYS-1:0] vld;
        logic [SETS-1:0][NUM_WAYS-1:0] dty;
        logic [SETS-1:0]               lru;
    } meta_t;

    meta_t                 meta_d, meta_q;
    logic [TAG_W-1:0]      tag_q [SETS][NUM_WAYS];
    logic [NUM_WAYS-1:0]   hv;

    generate
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
            assign hv[w] = meta_q.vld[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        end
    endgenerate

    always_comb begin
        hit_o      = |hv;
        hit_way_o  = hv[1];
        if (!meta_q.vld[lk_set][0]) begin
            vict_way_o = 1'b0;
        end else if (!meta_q.vld[lk_set][1]) begin
            vict_way_o = 1'b1;
        end else begin
            vict_way_o = meta_q.lru[lk_set];
        end
        vict_valid_o = meta_q.vld[lk_set][vict_way_o];
        vict_dirty_o = meta_q.dty[lk_set][vict_way_o];
        vict_tag_o   = tag_q[lk_set][vict_way_o];
    end

    always_comb begin
        meta_d = meta_q;
        if (upd_en_i) begin
            meta_d.vld[lk_set][upd_way_i] = 1'b1;
            if (upd_refill_i) begin
                meta_d.dty[lk_set][upd_way_i] = upd_write_i;
            end else begin
                meta_d.dty[lk_set][upd_way_i] = meta_q.dty[lk_set][upd_way_i] | upd_write_i;
            end
            meta_d.lru[lk_set] = ~upd_way_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
        end else begin
            meta_q <= meta_d;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en_i && upd_refill_i) begin
            tag_q[lk_set][upd_way_i] <= lk_tag;
        end
    end

    p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hv) <= 1);

    p_dirty_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vict_dirty_o |-> vict_valid_o);
endmodule

// File: rtl/wic_data_store.sv
module wic_data_store #(
    parameter int SETS = 128,
    parameter int SUBW = 2
) (
    input  logic                          clk,
    input  logic [$clog2(SETS)-1:0]       set_i,
    input  logic                          hit_way_i,
    input  logic                          vict_way_i,
    output logic [SUBW-1:0][31:0]         rd_hit_o,
    output logic [SUBW-1:0][31:0]         rd_vict_o,
    input  logic                          we_i,
    input  logic                          wr_way_i,
    input  logic [SUBW-1:0][31:0]         wr_data_i
);
    import wic_pkg::*;

    logic [SUBW-1:0][31:0] dat_q [SETS][NUM_WAYS];

    assign rd_hit_o  = dat_q[set_i][hit_way_i];
    assign rd_vict_o = dat_q[set_i][vict_way_i];

    always_ff @(posedge clk) begin
        if (we_i) begin
            dat_q[set_i][wr_way_i] <= wr_data_i;
        end
    end
endmodule

// File: rtl/wic_rsp_lane.sv
module wic_rsp_lane #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] lat_i,
    input  logic [31:0]      data_i,
    input  logic [1:0]       kind_i,
    output logic             busy_o,
    output logic             vld_o,
    output logic [31:0]      data_o,
    output logic [1:0]       kind_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      data;
        logic [1:0]       kind;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (load_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = lat_i - 1'b1;
            st_d.data = data_i;
            st_d.kind = kind_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign vld_o  = st_q.busy && (st_q.cnt == '0);
    assign data_o = st_q.data;
    assign kind_o = st_q.kind;

    p_load_when_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !st_q.busy);

    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);
endmodule

// File: rtl/wic_slice.sv
module wic_slice #(
    parameter int CLUSTERS    = 4,
    parameter int OWN_ID      = 0,
    parameter int ADDR_W      = 32,
    parameter int WORD_BYTES  = 4,
    parameter int BLOCK_BYTES = 32,
    parameter int CACHE_BYTES = 8192,
    parameter int LAT_LH      = 1,
    parameter int LAT_RH      = 5,
    parameter int LAT_LM      = 10,
    parameter int LAT_RM      = 15
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [1:0]                  req_src,
    input  logic [31:0]                 req_addr,
    input  logic [31:0]                 req_wdata,
    output logic [3:0]                  rsp_valid,
    output logic [127:0]                rsp_data,
    output logic [7:0]                  rsp_kind,
    output logic [31:0]                 l2_rd_addr,
    input  logic [63:0]                 l2_rd_data,
    output logic                        l2_wr_en,
    output logic [31:0]                 l2_wr_addr,
    output logic [63:0]                 l2_wr_data
);
    import wic_pkg::*;

    localparam int SRC_W   = $clog2(CLUSTERS);
    localparam int OFF_W   = $clog2(BLOCK_BYTES);
    localparam int SETS    = CACHE_BYTES / (BLOCK_BYTES * NUM_WAYS);
    localparam int SET_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - OFF_W - SET_W;
    localparam int OWN_LO  = $clog2(WORD_BYTES);
    localparam int SUBW    = BLOCK_BYTES / (WORD_BYTES * CLUSTERS);
    localparam int SW_W    = (SUBW > 1) ? $clog2(SUBW) : 1;
    localparam int WSEL_LO = OWN_LO + SRC_W;
    localparam int CNT_W   = $clog2(LAT_RM + 1);

    logic                  own, acc, hit, hit_way, vict_way, vict_valid, vict_dirty, use_way;
    logic [TAG_W-1:0]      vict_tag;
    logic [SET_W-1:0]      set_idx;
    logic [TAG_W-1:0]      tag_in;
    logic [SW_W-1:0]       wsel;
    logic [SUBW-1:0][31:0] rd_hit, rd_vict, base, merged;
    logic [31:0]           word_out;
    logic [1:0]            kind;
    logic [CNT_W-1:0]      lat_sel;
    logic [CLUSTERS-1:0]   busy_vec, load_vec;
    logic                  unused_bits;

    assign unused_bits = ^{req_addr[OWN_LO-1:0]};

    assign set_idx = req_addr[OFF_W +: SET_W];
    assign tag_in  = req_addr[ADDR_W-1 -: TAG_W];
    assign wsel    = req_addr[WSEL_LO +: SW_W];
    assign own     = (req_addr[OWN_LO +: SRC_W] == SRC_W'(OWN_ID));
    assign acc     = req_valid && own && !busy_vec[req_src];

    wic_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_set       (set_idx),
        .lk_tag       (tag_in),
        .hit_o        (hit),
        .hit_way_o    (hit_way),
        .vict_way_o   (vict_way),
        .vict_valid_o (vict_valid),
        .vict_dirty_o (vict_dirty),
        .vict_tag_o   (vict_tag),
        .upd_en_i     (acc),
        .upd_way_i    (use_way),
        .upd_refill_i (!hit),
        .upd_write_i  (req_write)
    );

    wic_data_store #(.SETS(SETS), .SUBW(SUBW)) u_data (
        .clk        (clk),
        .set_i      (set_idx),
        .hit_way_i  (hit_way),
        .vict_way_i (vict_way),
        .rd_hit_o   (rd_hit),
        .rd_vict_o  (rd_vict),
        .we_i       (acc && (req_write || !hit)),
        .wr_way_i   (use_way),
        .wr_data_i  (merged)
    );

    always_comb begin
        use_way = hit ? hit_way : vict_way;
        base    = hit ? rd_hit : l2_rd_data;
        merged  = base;
        if (req_write) begin
            merged[wsel] = req_wdata;
        end
        word_out = merged[wsel];
        kind     = {!hit, req_src != SRC_W'(OWN_ID)};
        case (kind)
            KIND_LHIT:  lat_sel = CNT_W'(LAT_LH);
            KIND_RHIT:  lat_sel = CNT_W'(LAT_RH);
            KIND_LMISS: lat_sel = CNT_W'(LAT_LM);
            default:    lat_sel = CNT_W'(LAT_RM);
        endcase
    end

    assign l2_rd_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign l2_wr_en   = acc && !hit && vict_valid && vict_dirty;
    assign l2_wr_addr = {vict_tag, set_idx, {OFF_W{1'b0}}};
    assign l2_wr_data = rd_vict;

    generate
        for (genvar l = 0; l < CLUSTERS; l++) begin : g_lane
            assign load_vec[l] = acc && (req_src == SRC_W'(l));
            wic_rsp_lane #(.CNT_W(CNT_W)) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .load_i (load_vec[l]),
                .lat_i  (lat_sel),
                .data_i (word_out),
                .kind_i (kind),
                .busy_o (busy_vec[l]),
                .vld_o  (rsp_valid[l]),
                .data_o (rsp_data[l*32 +: 32]),
                .kind_o (rsp_kind[l*2 +: 2])
            );
        end
    endgenerate

    p_one_lane_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_vec));

    p_nonowner_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !own) |-> (load_vec == '0 && !l2_wr_en));
endmodule

// File: tb/wic_slice_bench.sv
module wic_slice_bench;
    localparam int ID = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]   req_src = '0;
    logic [31:0]  req_addr = '0, req_wdata = '0;
    logic [3:0]   rsp_valid;
    logic [127:0] rsp_data;
    logic [7:0]   rsp_kind;
    logic [31:0]  l2_rd_addr, l2_wr_addr;
    logic [63:0]  l2_rd_data = '0, l2_wr_data;
    logic         l2_wr_en;

    always #4 clk = ~clk;

    wic_slice #(.OWN_ID(ID)) u_wic_slice (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_src(req_src), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_kind(rsp_kind),
        .l2_rd_addr(l2_rd_addr), .l2_rd_data(l2_rd_data), .l2_wr_en(l2_wr_en),
        .l2_wr_addr(l2_wr_addr), .l2_wr_data(l2_wr_data)
    );

    int nvec = 0, nfail = 0, cyc = 0;
    bit done = 0;

    bit [31:0] gmem [int unsigned];
    bit [31:0] l2m  [int unsigned];

    bit [19:0] mtag [128][2];
    bit        mval [128][2];
    bit        mdty [128][2];
    bit        mlru [128];

    bit        pend [4];
    int        due  [4];
    bit [31:0] edata[4];
    bit [1:0]  ekind[4];

    function automatic bit [31:0] init_val(int unsigned wa);
        return (wa * 32'h9E3779B1) ^ 32'hC0DE1234;
    endfunction
    function automatic bit [31:0] gread(int unsigned wa);
        return gmem.exists(wa) ? gmem[wa] : init_val(wa);
    endfunction
    function automatic bit [31:0] l2read(int unsigned wa);
        return l2m.exists(wa) ? l2m[wa] : init_val(wa);
    endfunction
    function automatic int lat_of(bit [1:0] k);
        case (k)
            2'd0: return 1;
            2'd1: return 5;
            2'd2: return 10;
            default: return 15;
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic step(bit v, bit wr, bit [1:0] src, bit [31:0] addr, bit [31:0] wd);
        bit acc, hit, way, wb;
        bit [6:0] set;
        bit [19:0] tag;
        int unsigned bw, wa;
        bit [1:0] k;
        @(negedge clk);
        for (int l = 0; l < 4; l++) begin
            bit exp_v;
            exp_v = pend[l] && (due[l] == cyc);
            if (exp_v || rsp_valid[l]) begin
                chk(rsp_valid[l] == exp_v, "R4", $sformatf("lane%0d valid", l), rsp_valid[l], exp_v);
                if (exp_v && rsp_valid[l]) begin
                    chk(rsp_data[l*32 +: 32] == edata[l], "R5", $sformatf("lane%0d data", l),
                        rsp_data[l*32 +: 32], edata[l]);
                    chk(rsp_kind[l*2 +: 2] == ekind[l], "R3", $sformatf("lane%0d kind", l),
                        rsp_kind[l*2 +: 2], ekind[l]);
                end
            end
        end
        req_valid = v; req_write = wr; req_src = src; req_addr = addr; req_wdata = wd;
        #1;
        bw = l2_rd_addr >> 2;
        l2_rd_data = {l2read(bw + 4 + ID), l2read(bw + ID)};
        #1;
        acc = v && (addr[3:2] == 2'(ID)) && !pend[src];
        if (acc) begin
            chk(l2_rd_addr == {addr[31:5], 5'b0}, "R7", "refill addr", l2_rd_addr, {addr[31:5], 5'b0});
            set = addr[11:5]; tag = addr[31:12];
            hit = 0; way = 0;
            for (int w = 0; w < 2; w++) if (mval[set][w] && mtag[set][w] == tag) begin hit = 1; way = w[0]; end
            wb = 0;
            if (!hit) begin
                way = !mval[set][0] ? 1'b0 : (!mval[set][1] ? 1'b1 : mlru[set]);
                wb = mval[set][way] && mdty[set][way];
            end
            chk(l2_wr_en == wb, "R8", "writeback enable", l2_wr_en, wb);
            if (wb && l2_wr_en) begin
                int unsigned vb;
                vb = {mtag[set][way], set, 5'b0} >> 2;
                chk(l2_wr_addr == {mtag[set][way], set, 5'b0}, "R8", "writeback addr",
                    l2_wr_addr, {mtag[set][way], set, 5'b0});
                chk(l2_wr_data == {gread(vb + 4 + ID), gread(vb + ID)}, "R8", "writeback data",
                    l2_wr_data, {gread(vb + 4 + ID), gread(vb + ID)});
            end
            wa = (addr >> 2);
            if (wr) gmem[wa] = wd;
            mval[set][way] = 1;
            mtag[set][way] = tag;
            mdty[set][way] = hit ? (mdty[set][way] | wr) : wr;
            mlru[set] = ~way;
            k = {!hit, src != 2'(ID)};
            pend[src] = 1; due[src] = cyc + lat_of(k); edata[src] = gread(wa); ekind[src] = k;
        end else begin
            chk(l2_wr_en == 0, v && addr[3:2] != 2'(ID) ? "R2" : "R10", "no writeback", l2_wr_en, 0);
        end
        if (l2_wr_en) begin
            l2m[(l2_wr_addr >> 2) + ID]     = l2_wr_data[31:0];
            l2m[(l2_wr_addr >> 2) + 4 + ID] = l2_wr_data[63:32];
        end
        for (int l = 0; l < 4; l++) if (pend[l] && due[l] == cyc) pend[l] = 0;
        cyc++;
    endtask

    function automatic bit [31:0] mk(bit [19:0] tag, bit [6:0] set, bit ws, bit [1:0] own);
        return {tag, set, ws, own, 2'b00};
    endfunction

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        bit [19:0] tpool [3];
        process::self().srandom(32'd12345);
        tpool[0] = 20'h12345; tpool[1] = 20'h00ABC; tpool[2] = 20'hFFFF0;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 0, "R1", "rsp during reset", rsp_valid, 0);
        chk(l2_wr_en == 0, "R1", "wb during reset", l2_wr_en, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 0, "R1", "rsp after reset", rsp_valid, 0);
        // R1 R3 R4 R7: first local access misses, then local hit, then remote hit
        step(1, 0, 2'(ID), mk(20'h00001, 7'd3, 0, 2'(ID)), 0);
        idle(11);
        step(1, 0, 2'(ID), mk(20'h00001, 7'd3, 1, 2'(ID)), 0);
        step(1, 0, 0, mk(20'h00001, 7'd3, 0, 2'(ID)), 0);
        idle(6);
        // R2: non-owned word ignored, owned word of that block still misses (remote miss)
        step(1, 1, 1, mk(20'h00002, 7'd9, 0, 2'(ID + 1)), 32'hDEADBEEF);
        idle(2);
        step(1, 0, 1, mk(20'h00002, 7'd9, 0, 2'(ID)), 0);
        idle(16);
        // R6 R8 R9: two dirty ways, third tag evicts LRU dirty way, then reread evicted
        step(1, 1, 2'(ID), mk(20'h00010, 7'd20, 0, 2'(ID)), 32'h11111111);
        idle(11);
        step(1, 1, 2'(ID), mk(20'h00020, 7'd20, 1, 2'(ID)), 32'h22222222);
        idle(11);
        step(1, 0, 2'(ID), mk(20'h00030, 7'd20, 0, 2'(ID)), 0);
        idle(11);
        step(1, 0, 3, mk(20'h00010, 7'd20, 0, 2'(ID)), 0);
        idle(16);
        // R10: second request from a busy requester is dropped
        step(1, 0, 1, mk(20'h00040, 7'd30, 0, 2'(ID)), 0);
        step(1, 1, 1, mk(20'h00040, 7'd31, 0, 2'(ID)), 32'h5555);
        idle(15);
        step(1, 0, 1, mk(20'h00040, 7'd31, 0, 2'(ID)), 0);
        idle(16);
        // R11: remote miss and local hit complete in the same cycle
        step(1, 0, 0, mk(20'h00050, 7'd40, 0, 2'(ID)), 0);
        idle(13);
        step(1, 0, 2'(ID), mk(20'h00001, 7'd3, 0, 2'(ID)), 0);
        idle(16);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit [1:0] own;
            own = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 3)) : 2'(ID);
            step($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 4, 2'($urandom_range(0, 3)),
                 mk(tpool[$urandom_range(0, 2)], 7'($urandom_range(5, 6)), 1'($urandom_range(0, 1)), own),
                 $urandom);
        end
        idle(20);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule